// File: doc/BRIEF.md
# Triangular-Sum Switch Decoder

This block turns a binary code into three one-hot select vectors for a converter built from three equal current sources. Each source can be steered into one of several taps of a resistor network. Tap k of that network adds a weight of k(k+1)/2 unit steps to the output. Every code from 0 up to the top of the input range can be written as the sum of at most three such triangular weights. The decoder picks one fixed split for each code and raises exactly one tap line per source. A source that is not needed parks on tap 0, which carries weight 0.

The split is deterministic. Array C takes the largest triangular weight that still leaves a remainder expressible as the sum of two triangular numbers. Array B then takes the largest weight that leaves a triangular remainder, and array A takes what is left. Two build options choose the implementation. One is a table of index triples computed at elaboration time. The other is a search circuit that evaluates the same rule in logic. A further option places a register with synchronous reset on the select outputs; without it, the outputs are combinational.

Top module: `tri_sum_dec`

## Requirements
- R1: The input is CODE_W bits wide (6 by default, codes 0 to 63). Each of the three arrays has as many lines as there are triangular numbers not above the largest code, which is 11 lines (0 to 10) by default. Line k carries weight k(k+1)/2, so line 10 carries 55.
- R2: Every array has exactly one line high in every cycle that is out of reset.
- R3: For every input code, weight(A) + weight(B) + weight(C) equals the code.
- R4: An array that the split does not need selects line 0. Code 0 selects line 0 on all three arrays. Code 55 selects line 10 on C and line 0 on A and B.
- R5: Array C holds the largest triangular weight whose remainder is a sum of two triangular numbers. Array B holds the largest weight whose remainder is triangular. Array A holds the rest, so weight(C) >= weight(B) >= weight(A). Code 5 gives A=1, B=1, C=2. Code 20 gives C=4, B=4, A=0. Code 63 gives C=9, B=5, A=2.
- R6: With REG_OUT=1, the outputs reflect the code sampled at the previous rising clk edge and do not change between edges. With REG_OUT=0, the outputs follow the code in the same cycle.
- R7: With REG_OUT=1, a synchronous active-high rst sets every array to line 0 (bit 0 high, all others low) at the next rising edge, whatever the code.
- R8: The table variant (USE_ROM=1) and the search variant (USE_ROM=0) produce identical selects for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| code_i | input | CODE_W | Binary code to decompose |
| sel_a_o | output | N_LINES | One-hot tap select for source A (smallest term) |
| sel_b_o | output | N_LINES | One-hot tap select for source B (middle term) |
| sel_c_o | output | N_LINES | One-hot tap select for source C (largest term) |

## Verification
The registered instance is due one rising edge after a code is applied. The bench drives each code on a falling edge and samples the registered selects on the following falling edge. It also samples once just after the drive, to confirm that the old value is still held. The combinational search instance is due in the same cycle, so it is sampled 1 ns after the drive. Reset is checked on the falling edge after the rising edge that captured rst high. The first code after reset release is checked one full cycle later.

// File: rtl/tri_dec_pkg.sv
package tri_dec_pkg;

   // number of current sources fed by the decoder
   localparam int unsigned N_SRC = 3;

   // widest index the shared search routine returns
   localparam int unsigned PICK_W = 8;

   typedef struct packed {
      logic [PICK_W-1:0] c;
      logic [PICK_W-1:0] b;
      logic [PICK_W-1:0] a;
   } pick_t;

   function automatic int unsigned tri_wt(input int unsigned k);
      return (k * (k + 1)) / 2;
   endfunction

   // count of triangular numbers not above the largest code
   function automatic int unsigned num_lines(input int unsigned code_w);
      int unsigned top;
      int unsigned n;
      top = (32'd1 << code_w) - 32'd1;
      n   = 0;
      while (tri_wt(n) <= top) n++;
      return n;
   endfunction

   function automatic bit is_tri(input int unsigned v, input int unsigned n);
      bit hit;
      hit = 1'b0;
      for (int unsigned k = 0; k < n; k++)
         if (tri_wt(k) == v) hit = 1'b1;
      return hit;
   endfunction

   function automatic bit is_pair(input int unsigned v, input int unsigned n);
      bit hit;
      hit = 1'b0;
      for (int unsigned j = 0; j < n; j++)
         if (tri_wt(j) <= v && is_tri(v - tri_wt(j), n)) hit = 1'b1;
      return hit;
   endfunction

   // fixed split: C largest feasible, then B largest leaving a triangle, A rest
   function automatic pick_t split3(input int unsigned v, input int unsigned n);
      pick_t       p;
      int unsigned rem;
      p = '0;
      for (int unsigned k = 0; k < n; k++)
         if (tri_wt(k) <= v && is_pair(v - tri_wt(k), n)) p.c = PICK_W'(k);
      rem = v - tri_wt(32'(p.c));
      for (int unsigned j = 0; j < n; j++)
         if (tri_wt(j) <= rem && is_tri(rem - tri_wt(j), n)) p.b = PICK_W'(j);
      rem = rem - tri_wt(32'(p.b));
      for (int unsigned i = 0; i < n; i++)
         if (tri_wt(i) == rem) p.a = PICK_W'(i);
      return p;
   endfunction

endpackage

// File: rtl/tri_pick_rom.sv
module tri_pick_rom
   import tri_dec_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter int N_LINES = 11,
   parameter int IDX_W   = 4
)(
   input  logic [CODE_W-1:0] code_i,
   output logic [IDX_W-1:0]  idx_a_o,
   output logic [IDX_W-1:0]  idx_b_o,
   output logic [IDX_W-1:0]  idx_c_o
);

   localparam int N_CODES = 1 << CODE_W;
   localparam int ENT_W   = 3 * IDX_W;

   logic [ENT_W-1:0] rom [N_CODES];

   // one table entry per code, each filled by the shared split rule
   for (genvar v = 0; v < N_CODES; v++) begin : g_ent
      localparam pick_t P = split3(v, N_LINES);
      assign rom[v] = {IDX_W'(P.c), IDX_W'(P.b), IDX_W'(P.a)};
   end

   assign {idx_c_o, idx_b_o, idx_a_o} = rom[code_i];

endmodule

// File: rtl/tri_pick_search.sv
module tri_pick_search
   import tri_dec_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter int N_LINES = 11,
   parameter int IDX_W   = 4
)(
   input  logic [CODE_W-1:0] code_i,
   output logic [IDX_W-1:0]  idx_a_o,
   output logic [IDX_W-1:0]  idx_b_o,
   output logic [IDX_W-1:0]  idx_c_o
);

   function automatic logic [3*IDX_W-1:0] pick_idx(input logic [CODE_W-1:0] v);
      pick_t p;
      p = split3(32'(v), N_LINES);
      return {IDX_W'(p.c), IDX_W'(p.b), IDX_W'(p.a)};
   endfunction

   always_comb begin
      {idx_c_o, idx_b_o, idx_a_o} = pick_idx(code_i);
   end

endmodule

// File: rtl/tri_onehot.sv
module tri_onehot #(
   parameter int N_LINES = 11,
   parameter int IDX_W   = 4
)(
   input  logic [IDX_W-1:0]   idx_i,
   output logic [N_LINES-1:0] line_o
);

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      assign line_o[l] = (idx_i == IDX_W'(l));
   end

endmodule

// File: rtl/tri_out_reg.sv
module tri_out_reg #(
   parameter int               WIDTH   = 33,
   parameter bit               REG_OUT = 1'b1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) q_o <= RST_VAL;
         else     q_o <= d_i;
      end
   end else begin : g_pass
      logic clk_rst_unused;
      assign clk_rst_unused = clk ^ rst;
      assign q_o = d_i;
   end

endmodule

// File: rtl/tri_sum_dec.sv
module tri_sum_dec
   import tri_dec_pkg::*;
#(
   parameter int  CODE_W  = 6,
   parameter bit  REG_OUT = 1'b1,
   parameter bit  USE_ROM = 1'b1,
   localparam int N_LINES = int'(num_lines(CODE_W)),
   localparam int IDX_W   = $clog2(N_LINES)
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [CODE_W-1:0]  code_i,
   output logic [N_LINES-1:0] sel_a_o,
   output logic [N_LINES-1:0] sel_b_o,
   output logic [N_LINES-1:0] sel_c_o
);

   localparam int SEL_W = int'(N_SRC) * N_LINES;
   localparam logic [SEL_W-1:0] PARK = {N_SRC{N_LINES'(1)}};

   if (CODE_W < 1 || CODE_W > 10) begin : g_bad_width
      $error("tri_sum_dec: CODE_W must lie in 1..10");
   end
   if (IDX_W > int'(PICK_W)) begin : g_bad_index
      $error("tri_sum_dec: tap index wider than search result");
   end

   logic [IDX_W-1:0] idx [N_SRC];
   logic [SEL_W-1:0] sel_d;
   logic [SEL_W-1:0] sel_q;

   if (USE_ROM) begin : g_rom
      tri_pick_rom #(
         .CODE_W (CODE_W),
         .N_LINES(N_LINES),
         .IDX_W  (IDX_W)
      ) u_pick (
         .code_i (code_i),
         .idx_a_o(idx[0]),
         .idx_b_o(idx[1]),
         .idx_c_o(idx[2])
      );
   end else begin : g_search
      tri_pick_search #(
         .CODE_W (CODE_W),
         .N_LINES(N_LINES),
         .IDX_W  (IDX_W)
      ) u_pick (
         .code_i (code_i),
         .idx_a_o(idx[0]),
         .idx_b_o(idx[1]),
         .idx_c_o(idx[2])
      );
   end

   for (genvar s = 0; s < int'(N_SRC); s++) begin : g_src
      tri_onehot #(
         .N_LINES(N_LINES),
         .IDX_W  (IDX_W)
      ) u_hot (
         .idx_i (idx[s]),
         .line_o(sel_d[s*N_LINES +: N_LINES])
      );
   end

   tri_out_reg #(
      .WIDTH  (SEL_W),
      .REG_OUT(REG_OUT),
      .RST_VAL(PARK)
   ) u_out (
      .clk(clk),
      .rst(rst),
      .d_i(sel_d),
      .q_o(sel_q)
   );

   assign sel_a_o = sel_q[0*N_LINES +: N_LINES];
   assign sel_b_o = sel_q[1*N_LINES +: N_LINES];
   assign sel_c_o = sel_q[2*N_LINES +: N_LINES];

endmodule

// File: rtl/tri_sum_dec_chk.sv
module tri_sum_dec_chk
   import tri_dec_pkg::*;
#(
   parameter int  CODE_W  = 6,
   parameter bit  REG_OUT = 1'b1,
   localparam int N_LINES = int'(num_lines(CODE_W))
)(
   input logic               clk,
   input logic               rst,
   input logic [CODE_W-1:0]  code_i,
   input logic [N_LINES-1:0] sel_a_o,
   input logic [N_LINES-1:0] sel_b_o,
   input logic [N_LINES-1:0] sel_c_o
);

   function automatic int unsigned wsum(input logic [N_LINES-1:0] v);
      int unsigned s;
      s = 0;
      for (int unsigned k = 0; k < N_LINES; k++)
         if (v[k]) s += tri_wt(k);
      return s;
   endfunction

   // R2
   one_hot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(sel_a_o) == 1 && $countones(sel_b_o) == 1 && $countones(sel_c_o) == 1)
      else $error("select array not one-hot");

   // R5
   term_order_chk: assert property (@(posedge clk) disable iff (rst)
      wsum(sel_c_o) >= wsum(sel_b_o) && wsum(sel_b_o) >= wsum(sel_a_o))
      else $error("terms out of order");

   if (REG_OUT) begin : g_reg_chk
      // R3
      exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> wsum(sel_a_o) + wsum(sel_b_o) + wsum(sel_c_o) == 32'($past(code_i)))
         else $error("weights do not add up to code");

      // R7
      reset_park_chk: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> sel_a_o == N_LINES'(1) && sel_b_o == N_LINES'(1) && sel_c_o == N_LINES'(1))
         else $error("reset did not park arrays");

      // R6
      hold_between_chk: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) && $stable(code_i) |=> $stable(sel_a_o) && $stable(sel_b_o) && $stable(sel_c_o))
         else $error("registered selects changed with steady code");
   end else begin : g_comb_chk
      // R3
      exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
         wsum(sel_a_o) + wsum(sel_b_o) + wsum(sel_c_o) == 32'(code_i))
         else $error("weights do not add up to code");
   end

endmodule

bind tri_sum_dec tri_sum_dec_chk #(
   .CODE_W (CODE_W),
   .REG_OUT(REG_OUT)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .code_i (code_i),
   .sel_a_o(sel_a_o),
   .sel_b_o(sel_b_o),
   .sel_c_o(sel_c_o)
);

// File: tb/sim_tri_sum_dec.sv
`timescale 1ns/1ps
module sim_tri_sum_dec;

   localparam int CW = 6;
   localparam int NL = 11;
   localparam int SW = 3 * NL;

   logic          clk  = 1'b0;
   logic          rst  = 1'b1;
   logic [CW-1:0] code = '0;
   logic [NL-1:0] a0, b0, c0, a1, b1, c1;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tri_sum_dec #(.CODE_W(CW), .REG_OUT(1'b1), .USE_ROM(1'b1)) u0 (
      .clk(clk), .rst(rst), .code_i(code),
      .sel_a_o(a0), .sel_b_o(b0), .sel_c_o(c0)
   );

   tri_sum_dec #(.CODE_W(CW), .REG_OUT(1'b0), .USE_ROM(1'b0)) u1 (
      .clk(clk), .rst(rst), .code_i(code),
      .sel_a_o(a1), .sel_b_o(b1), .sel_c_o(c1)
   );

   function automatic int tw(input int k);
      return (k * (k + 1)) / 2;
   endfunction

   function automatic logic [SW-1:0] mk(input int c, input int b, input int a);
      return {NL'(1) << c, NL'(1) << b, NL'(1) << a};
   endfunction

   // brute force: first triple c>=b>=a, searched from the top, whose weights sum to v
   function automatic logic [SW-1:0] ref_sel(input int v);
      logic [SW-1:0] r;
      bit            found;
      r = '0;
      found = 1'b0;
      for (int c = NL - 1; c >= 0; c--)
         for (int b = c; b >= 0; b--)
            for (int a = b; a >= 0; a--)
               if (!found && tw(c) + tw(b) + tw(a) == v) begin
                  r = mk(c, b, a);
                  found = 1'b1;
               end
      return r;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_hot(input string req, input logic [NL-1:0] v);
      n_chk++;
      if ($countones(v) != 1) begin
         n_fail++;
         $display("FAIL %s one-hot: got %b expected exactly one bit", req, v);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic run_code(input int v, input string req);
      logic [SW-1:0] e;
      e = ref_sel(v);
      @(negedge clk);
      code = CW'(v);
      #1;
      chk("R8", "search variant same cycle", {c1, b1, a1}, e);
      @(negedge clk);
      chk(req, $sformatf("table variant code %0d", v), {c0, b0, a0}, e);
      chk_hot("R2", a0);
      chk_hot("R2", b0);
      chk_hot("R2", c0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      code = 6'd37;
      repeat (3) @(negedge clk);
      // R7: reset parks all arrays on line 0
      chk("R7", "initial reset", {c0, b0, a0}, mk(0, 0, 0));
      rst = 1'b0;

      // R4, R5, R1: directed corner codes with hand-computed selects
      run_code(0, "R4");
      chk("R4", "code 0 parks all", {c0, b0, a0}, mk(0, 0, 0));
      run_code(55, "R1");
      chk("R4", "code 55 top line only", {c0, b0, a0}, mk(10, 0, 0));
      run_code(5, "R5");
      chk("R5", "code 5 split", {c0, b0, a0}, mk(2, 1, 1));
      run_code(20, "R5");
      chk("R5", "code 20 split", {c0, b0, a0}, mk(4, 4, 0));
      run_code(63, "R5");
      chk("R5", "code 63 split", {c0, b0, a0}, mk(9, 5, 2));

      // R3: exhaustive sweep of the input range
      for (int v = 0; v < (1 << CW); v++) run_code(v, "R3");

      // R6: registered output holds until the next rising edge
      run_code(9, "R6");
      @(negedge clk);
      code = 6'd40;
      #1;
      chk("R6", "held before edge", {c0, b0, a0}, ref_sel(9));
      chk("R6", "comb follows at once", {c1, b1, a1}, ref_sel(40));
      @(negedge clk);
      chk("R6", "updated after edge", {c0, b0, a0}, ref_sel(40));

      // R7: mid-run reset overrides a live code
      @(negedge clk);
      code = 6'd63;
      rst  = 1'b1;
      @(negedge clk);
      chk("R7", "mid-run reset", {c0, b0, a0}, mk(0, 0, 0));
      rst = 1'b0;
      @(negedge clk);
      chk("R7", "first code after reset", {c0, b0, a0}, ref_sel(63));

      // R3: random codes
      for (int i = 0; i < 400; i++) run_code(int'($urandom_range(63, 0)), "R3");

      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog: got no completion expected completion within 20000 cycles");
         report();
      end
   end

endmodule